// File: doc/BRIEF.md
# Character LCD Power-On Initialiser

This block brings a character LCD controller out of power-up when the controller is wired for a 4-bit data bus. It does not touch the LCD pins itself. Instead it asks a separate bus engine for transfers through two request ports. The nibble port carries one raw 4-bit value and one enable pulse. The byte port carries a full byte, either a command write or a status read, as two nibble phases. The engine answers each request with a one-cycle acknowledge, and for a status read it returns the byte it read.

After `start`, the block has the engine park every LCD line low as an output and holds off for a long power-up wait. It then sends three raw nibbles, one enable pulse each: the first selects the 4-bit bus, and the next two form the function-set command. During this phase the controller cannot yet answer a status read, so only fixed delays pace it. After a short settle wait the block switches to busy-flag polling. It writes the function-set command (4-bit bus, two lines, 5x8 font), polls again, and writes display-on. Only then does it raise `done`. Clearing the screen text is left to the console logic downstream.

Top module: `lcd_power_on_init`

## Requirements
- R1: After reset, `done`, `bus_park`, `nib_req` and `byte_req` are all low, and they stay low until `start` is sampled high.
- R2: From the edge that samples `start`, `bus_park` is high for exactly PWR_WAIT_CYC+1 cycles, and no request is raised while it is high.
- R3: The first nibble request rises at the (PWR_WAIT_CYC+2)-th rising edge after the edge that samples `start`.
- R4: The raw start-up phase consists of exactly three nibble transfers, with `nib_val` equal to 0x2, then 0x2, then 0x8, each one its own request.
- R5: `byte_req` first rises at the (SETTLE_CYC+2)-th rising edge after the edge that accepts the third nibble.
- R6: A status poll is a byte request with `byte_rd`=1 and `byte_wdata`=0x00. The poll is repeated while bit 7 of `eng_rdata` is 1 at its acknowledge. Bits 6..0 of the status have no effect.
- R7: After the first poll that returns bit 7 clear, the block writes command 0x28 (`byte_rd`=0). It then polls again in the same way, and after that poll clears it writes command 0x0C.
- R8: `done` rises on the edge after the 0x0C write is acknowledged, never earlier. It stays high with no requests and `bus_park` low until the next `start`.
- R9: A `start` sampled in any state, including during a wait or while `done` is high, clears `done`, withdraws any pending request and restarts the sequence from R2.
- R10: A request stays high with a stable payload until an edge samples it together with `eng_ack`. It is low on the following cycle, so there is at least one low cycle between transfers. `nib_req` and `byte_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins, or restarts, the power-up sequence |
| done | output | 1 | High once the display-on command has completed |
| bus_park | output | 1 | Asks the engine to drive all LCD lines low as outputs |
| nib_req | output | 1 | Raw single-nibble transfer request |
| nib_val | output | 4 | Nibble to place on the data lines |
| byte_req | output | 1 | Full byte transfer request |
| byte_rd | output | 1 | 1 = status read, 0 = command write |
| byte_wdata | output | 8 | Command byte for a write, 0x00 for a read |
| eng_ack | input | 1 | Engine completion strobe for the pending request |
| eng_rdata | input | 8 | Status byte returned with the acknowledge of a read |

## Verification
The bench counts edges exactly from `start` to the first nibble request and from the third nibble acknowledge to the first poll. A design with an off-by-one in either wait, or one that skips the settle wait, shows up as a wrong count. Poll phases are run with zero, several and uneven numbers of busy replies. Some ready replies carry nonzero address bits, so a design that tests the whole status byte instead of bit 7 would keep polling and fall out of step with the scoreboard. Restarts are issued in the middle of the power-up wait and after `done`. A design that ignores the second `start` gets the timing wrong, and one that keeps `done` high gets caught. The engine model also checks that each request drops right after its acknowledge, so a sequencer that chains transfers without a gap gets caught.

// File: rtl/lcdi_pkg.sv
// Shared types and constants for the LCD power-on initialiser.
package lcdi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PARK,
        ST_NIB_A,
        ST_NIB_B,
        ST_NIB_C,
        ST_SETTLE,
        ST_POLL_FN,
        ST_CMD_FN,
        ST_POLL_ON,
        ST_CMD_ON,
        ST_DONE
    } seq_state_t;

    localparam logic [3:0] NIB_BUS4   = 4'h2;
    localparam logic [3:0] NIB_FN_HI  = 4'h2;
    localparam logic [3:0] NIB_FN_LO  = 4'h8;
    localparam logic [7:0] CMD_FN_SET = 8'h28;
    localparam logic [7:0] CMD_DISP_ON = 8'h0C;
    localparam int         BUSY_BIT   = 7;
    localparam int         BYTE_REQ_W = 9;   // {read flag, data byte}

endpackage

// File: rtl/lcdi_wait_timer.sv
// Countdown delay timer.
// Loads a cycle count and decrements it to zero; expired is high at zero.
// Assumes the user loads it when entering a wait and watches expired.
module lcdi_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Load has priority; otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lcdi_req_hold.sv
// Request holding register for one engine port.
// Raises req with a payload on launch and keeps both until an edge sees ack.
// Assumes the launcher never launches while req is already high.
module lcdi_req_hold #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         launch,
    input  logic [W-1:0] launch_data,
    input  logic         ack,
    output logic         req,
    output logic [W-1:0] data
);
    // Request flag: set by launch, cleared by ack or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            req <= 1'b0;
        else if (launch)
            req <= 1'b1;
        else if (req && ack)
            req <= 1'b0;
    end

    // Payload: captured on launch, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            data <= '0;
        else if (launch)
            data <= launch_data;
    end
endmodule

// File: rtl/lcdi_seq_fsm.sv
// Power-up sequencer for a 4-bit character LCD.
// Walks park/wait, three raw nibbles, settle wait, then busy-polled
// function-set and display-on commands. Every request state launches
// only while its port is idle, which gives one idle cycle after each ack.
// Assumes eng_ack is meaningful only while the matching request is high.
module lcdi_seq_fsm
    import lcdi_pkg::*;
#(
    parameter int CW           = 8,
    parameter int PWR_WAIT_CYC = 100,
    parameter int SETTLE_CYC   = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  tmr_expired,
    output logic                  tmr_load,
    output logic [CW-1:0]         tmr_val,
    input  logic                  nib_req,
    input  logic                  byte_req,
    input  logic                  eng_ack,
    input  logic                  status_busy,
    output logic                  flush,
    output logic                  nib_launch,
    output logic [3:0]            nib_launch_val,
    output logic                  byte_launch,
    output logic [BYTE_REQ_W-1:0] byte_launch_val,
    output logic                  park,
    output logic                  done
);
    localparam logic [CW-1:0] PWR_LOAD    = CW'(PWR_WAIT_CYC);
    localparam logic [CW-1:0] SETTLE_LOAD = CW'(SETTLE_CYC);
    localparam logic [BYTE_REQ_W-1:0] POLL_WORD = {1'b1, 8'h00};

    seq_state_t st, st_nxt;
    logic nib_xfer, byte_xfer;

    assign nib_xfer  = nib_req && eng_ack;
    assign byte_xfer = byte_req && eng_ack;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    // Next state, timer loads and request launches.
    always_comb begin
        st_nxt          = st;
        tmr_load        = 1'b0;
        tmr_val         = PWR_LOAD;
        nib_launch      = 1'b0;
        nib_launch_val  = '0;
        byte_launch     = 1'b0;
        byte_launch_val = '0;
        flush           = start;
        if (start) begin
            st_nxt   = ST_PARK;
            tmr_load = 1'b1;
            tmr_val  = PWR_LOAD;
        end else begin
            unique case (st)
                ST_IDLE: st_nxt = ST_IDLE;
                ST_PARK: if (tmr_expired) st_nxt = ST_NIB_A;
                ST_NIB_A: begin
                    if (nib_xfer) st_nxt = ST_NIB_B;
                    else if (!nib_req) begin
                        nib_launch     = 1'b1;
                        nib_launch_val = NIB_BUS4;
                    end
                end
                ST_NIB_B: begin
                    if (nib_xfer) st_nxt = ST_NIB_C;
                    else if (!nib_req) begin
                        nib_launch     = 1'b1;
                        nib_launch_val = NIB_FN_HI;
                    end
                end
                ST_NIB_C: begin
                    if (nib_xfer) begin
                        st_nxt   = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = SETTLE_LOAD;
                    end else if (!nib_req) begin
                        nib_launch     = 1'b1;
                        nib_launch_val = NIB_FN_LO;
                    end
                end
                ST_SETTLE: if (tmr_expired) st_nxt = ST_POLL_FN;
                ST_POLL_FN: begin
                    if (byte_xfer) begin
                        if (!status_busy) st_nxt = ST_CMD_FN;
                    end else if (!byte_req) begin
                        byte_launch     = 1'b1;
                        byte_launch_val = POLL_WORD;
                    end
                end
                ST_CMD_FN: begin
                    if (byte_xfer) st_nxt = ST_POLL_ON;
                    else if (!byte_req) begin
                        byte_launch     = 1'b1;
                        byte_launch_val = {1'b0, CMD_FN_SET};
                    end
                end
                ST_POLL_ON: begin
                    if (byte_xfer) begin
                        if (!status_busy) st_nxt = ST_CMD_ON;
                    end else if (!byte_req) begin
                        byte_launch     = 1'b1;
                        byte_launch_val = POLL_WORD;
                    end
                end
                ST_CMD_ON: begin
                    if (byte_xfer) st_nxt = ST_DONE;
                    else if (!byte_req) begin
                        byte_launch     = 1'b1;
                        byte_launch_val = {1'b0, CMD_DISP_ON};
                    end
                end
                ST_DONE: st_nxt = ST_DONE;
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    assign park = (st == ST_PARK);
    assign done = (st == ST_DONE);
endmodule

// File: rtl/lcd_power_on_init.sv
// Top of the LCD power-on initialiser.
// Joins the sequencer, the delay timer and one request register per engine
// port. Assumes a bus engine that performs nibble and byte transfers and
// pulses eng_ack once per accepted request.
module lcd_power_on_init
    import lcdi_pkg::*;
#(
    parameter int PWR_WAIT_CYC = 1_600_000,  // 32 ms at 50 MHz
    parameter int SETTLE_CYC   = 2_000       // 40 us at 50 MHz
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       done,
    output logic       bus_park,
    output logic       nib_req,
    output logic [3:0] nib_val,
    output logic       byte_req,
    output logic       byte_rd,
    output logic [7:0] byte_wdata,
    input  logic       eng_ack,
    input  logic [7:0] eng_rdata
);
    localparam int MAX_WAIT = (PWR_WAIT_CYC > SETTLE_CYC) ? PWR_WAIT_CYC : SETTLE_CYC;
    localparam int CW       = $clog2(MAX_WAIT + 1);

    logic                  tmr_load, tmr_expired, flush;
    logic [CW-1:0]         tmr_val;
    logic                  nib_launch, byte_launch;
    logic [3:0]            nib_launch_val;
    logic [BYTE_REQ_W-1:0] byte_launch_val, byte_word;
    logic                  unused_status_bits;

    assign unused_status_bits = ^eng_rdata[BUSY_BIT-1:0];

    lcdi_seq_fsm #(
        .CW(CW), .PWR_WAIT_CYC(PWR_WAIT_CYC), .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .nib_req(nib_req), .byte_req(byte_req), .eng_ack(eng_ack),
        .status_busy(eng_rdata[BUSY_BIT]), .flush(flush),
        .nib_launch(nib_launch), .nib_launch_val(nib_launch_val),
        .byte_launch(byte_launch), .byte_launch_val(byte_launch_val),
        .park(bus_park), .done(done)
    );

    lcdi_wait_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_expired)
    );

    lcdi_req_hold #(.W(4)) u_nib_port (
        .clk(clk), .rst_n(rst_n), .flush(flush), .launch(nib_launch),
        .launch_data(nib_launch_val), .ack(eng_ack),
        .req(nib_req), .data(nib_val)
    );

    lcdi_req_hold #(.W(BYTE_REQ_W)) u_byte_port (
        .clk(clk), .rst_n(rst_n), .flush(flush), .launch(byte_launch),
        .launch_data(byte_launch_val), .ack(eng_ack),
        .req(byte_req), .data(byte_word)
    );

    assign byte_rd    = byte_word[BYTE_REQ_W-1];
    assign byte_wdata = byte_word[7:0];
endmodule

// File: rtl/lcdi_init_checks.sv
// Protocol checker for lcd_power_on_init, attached by bind.
module lcdi_init_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       done,
    input logic       bus_park,
    input logic       nib_req,
    input logic [3:0] nib_val,
    input logic       byte_req,
    input logic       byte_rd,
    input logic [7:0] byte_wdata,
    input logic       eng_ack
);
    assert_park_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_park |-> (!nib_req && !byte_req));

    assert_nib_values_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nib_req |-> (nib_val == 4'h2 || nib_val == 4'h8));

    assert_poll_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && byte_rd) |-> (byte_wdata == 8'h00));

    assert_done_after_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(byte_req && eng_ack && !byte_rd && byte_wdata == 8'h0C));

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!nib_req && !byte_req && !bus_park));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (bus_park && !done && !nib_req && !byte_req));

    assert_nib_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_req && eng_ack) |=> !nib_req);

    assert_byte_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && eng_ack) |=> !byte_req);

    assert_nib_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_req && !eng_ack && !start) |=> (nib_req && $stable(nib_val)));

    assert_byte_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && !eng_ack && !start) |=> (byte_req && $stable(byte_wdata) && $stable(byte_rd)));

    assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(nib_req && byte_req));
endmodule

bind lcd_power_on_init lcdi_init_checks u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .bus_park(bus_park),
    .nib_req(nib_req), .nib_val(nib_val), .byte_req(byte_req),
    .byte_rd(byte_rd), .byte_wdata(byte_wdata), .eng_ack(eng_ack)
);

// File: tb/lcd_power_on_init_tb.sv
// Scoreboard bench: the driver queues expected transfers and status replies,
// the engine model pops and compares each transfer as it is acknowledged.
module lcd_power_on_init_tb;
    localparam int PWR = 40;
    localparam int SET = 10;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       done, bus_park, nib_req, byte_req, byte_rd;
    logic [3:0] nib_val;
    logic [7:0] byte_wdata;
    logic       eng_ack = 1'b0;
    logic [7:0] eng_rdata = 8'h00;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int exp_q[$];      // {kind[9:8], byte}: 0 nibble, 1 status read, 2 command write
    int stat_q[$];     // status bytes returned by the engine model

    bit settle_armed = 0;
    int settle_k     = 0;

    always #4 clk = ~clk;   // 125 MHz

    lcd_power_on_init #(.PWR_WAIT_CYC(PWR), .SETTLE_CYC(SET)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .bus_park(bus_park), .nib_req(nib_req), .nib_val(nib_val),
        .byte_req(byte_req), .byte_rd(byte_rd), .byte_wdata(byte_wdata),
        .eng_ack(eng_ack), .eng_rdata(eng_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Engine model and scoreboard monitor.
    initial begin : engine
        int lat;
        int item;
        int want;
        lat = 0;
        forever begin
            @(negedge clk);
            if (settle_armed) begin
                settle_k++;
                if (byte_req) begin
                    check(settle_k == SET + 3, "R5 settle edges", settle_k - 1, SET + 2);
                    settle_armed = 0;
                end
            end
            if (eng_ack) begin
                eng_ack = 1'b0;
                check(!nib_req && !byte_req, "R10 drop after ack", {nib_req, byte_req}, 0);
            end else if (nib_req || byte_req) begin
                lat++;
                if (lat >= LAT) begin
                    lat = 0;
                    item = nib_req ? int'(nib_val) : (byte_rd ? (256 | byte_wdata) : (512 | byte_wdata));
                    want = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                    check(item == want, "R4/R6/R7 transfer", item, want);
                    check(!done, "R8 done early", done, 0);
                    if (byte_req && byte_rd)
                        eng_rdata = (stat_q.size() > 0) ? 8'(stat_q.pop_front()) : 8'h00;
                    if (item == 8) begin
                        settle_armed = 1;
                        settle_k = 0;
                    end
                    eng_ack = 1'b1;
                end
            end else begin
                lat = 0;
            end
        end
    end

    // Queue the expected transfers and status replies of one full bring-up.
    task automatic queue_run(input int busy1, input int busy2, input int ready);
        exp_q.delete();
        stat_q.delete();
        exp_q.push_back(2); exp_q.push_back(2); exp_q.push_back(8);
        for (int i = 0; i < busy1; i++) begin
            exp_q.push_back(256); stat_q.push_back(8'h80 | i);
        end
        exp_q.push_back(256); stat_q.push_back(ready);
        exp_q.push_back(512 | 8'h28);
        for (int i = 0; i < busy2; i++) begin
            exp_q.push_back(256); stat_q.push_back(8'hC0 | i);
        end
        exp_q.push_back(256); stat_q.push_back(ready);
        exp_q.push_back(512 | 8'h0C);
    endtask

    // Pulse start and time the park window and the first nibble request.
    task automatic start_and_time();
        int k;
        bit park_ok;
        k = 0;
        park_ok = 1;
        @(negedge clk);
        start = 1'b1;
        do begin
            @(negedge clk);
            start = 1'b0;
            k++;
            if (!nib_req && (bus_park != (k <= PWR + 1))) park_ok = 0;
            if (byte_req) park_ok = 0;
        end while (!nib_req && k < PWR + 20);
        check(park_ok, "R2 park window", park_ok, 1);
        check(k == PWR + 3, "R3 first nibble edge", k - 1, PWR + 2);
    endtask

    task automatic finish_run(input string tag);
        int t;
        bit quiet;
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(done, "R8 done reached", done, 1);
        check(exp_q.size() == 0, "R7 all transfers seen", exp_q.size(), 0);
        check(settle_armed == 0, "R5 poll started", settle_armed, 0);
        quiet = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!done || nib_req || byte_req || bus_park) quiet = 0;
        end
        check(quiet, "R8 done holds", quiet, 1);
        $display("run %s complete", tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : driver
        bit idle_ok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        idle_ok = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done || bus_park || nib_req || byte_req) idle_ok = 0;
        end
        check(idle_ok, "R1 reset idle", idle_ok, 1);
        check(!done, "R1 done low", done, 0);

        // Ready at once, ready status all zero.
        queue_run(0, 0, 8'h00);
        start_and_time();
        finish_run("A");

        // Busy replies, ready status with address bits set (R6).
        queue_run(3, 2, 8'h7F);
        start_and_time();
        finish_run("B");

        // Restart from done, then restart again mid power-up wait (R9).
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done && bus_park, "R9 restart from done", {done, bus_park}, 1);
        repeat (10) @(negedge clk);
        check(bus_park && !nib_req, "R9 still parked", bus_park, 1);
        queue_run(1, 4, 8'h3A);
        start_and_time();
        finish_run("C");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule